// File: doc/BRIEF.md
# Power-Supply Fault Latch and On/Off Sequencer

This block is the digital core of a supervisor for a multi-rail switching power supply. Analog comparators outside the block supply per-rail flags: over-voltage and over-current on three main rails, under-voltage on the highest rail, and a power-good input level. The block also takes an active-low on/off request and a supply-lockout signal. It drives a rails-off output and a fault-held status flag. Whenever `rails_off` is high, the converter must hold its main rails at zero.

Every time interval counts ticks of a 1 µs clock-enable strobe, and each interval is a parameter. The on/off request is debounced in both directions. Turning on takes effect as soon as the debounced request goes low. Turning off adds a further delay before the rails are dropped. A fault stays latched from the moment it qualifies until a completed turn-off or a lockout. Each fault flag must stay high for its own deglitch window, and the window restarts if the flag drops early. Over-current and 12 V under-voltage checking is armed only after a blanking interval that starts at turn-on and runs while power-good is high, so slow-rising rails cannot trip the supply. Both checks are masked while power-good is low. Over-voltage is never masked.

Top module: `psu_guard`

## Requirements
- R1: After reset, and in the cycle after `lockout` is sampled high, `rails_off` is 1 and `fault_held` is 0. A lockout also returns the debounced request to the off state.
- R2: A change of `on_req_n` takes effect only after it has been sampled at its new level on DEB_TICKS consecutive ticks. A shorter excursion has no effect on `rails_off`.
- R3: When the debounced request becomes on (0) and no fault is held, `rails_off` falls at that same clock edge.
- R4: When the debounced request becomes off (1), `rails_off` rises OFF_TICKS ticks later.
- R5: An over-voltage flag on any rail (`ov_flag` bit 0, 1 or 2) that is sampled high for more than OV_TICKS ticks sets `fault_held`. This happens whatever the level of `pg_in`.
- R6: Over-current checking is armed once the debounced request has been on and `pg_in` has been high for ARM_TICKS consecutive ticks. Once armed, any `oc_flag` bit held for more than OC_TICKS ticks sets `fault_held`. Before arming, over-current flags have no effect.
- R7: Once armed, `uv12_flag` held for more than UV_TICKS ticks sets `fault_held`.
- R8: While `pg_in` is low, `oc_flag` and `uv12_flag` cannot set `fault_held`.
- R9: If a fault flag drops before its window has expired, that flag's count restarts from zero.
- R10: `fault_held` forces `rails_off` high. The latch is cleared only when a turn-off completes (that is, when `rails_off` rises because of R4) or by a lockout.
- R11: All timers advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 1 µs clock-enable strobe for all timers |
| lockout | input | 1 | Supply lockout; acts as a synchronous clear of the whole block |
| on_req_n | input | 1 | On/off request, 0 = rails on |
| pg_in | input | 1 | Power-good input level |
| ov_flag | input | 3 | Over-voltage comparator flags, one per rail |
| oc_flag | input | 3 | Over-current comparator flags, one per rail |
| uv12_flag | input | 1 | Under-voltage flag of the 12 V rail |
| rails_off | output | 1 | 1 = main rails must be off |
| fault_held | output | 1 | 1 = a protection fault is latched |

## Verification
The bench keeps `tick` high except in the tick-gating scenario, so one tick equals one clock edge. A debounced request change becomes visible at the DEB_TICKS-th edge. The rails-off rise for a turn-off lands DEB_TICKS+OFF_TICKS edges after the request changes. A fault flag held from a given edge sets the latch at edge OV/OC/UV_TICKS+1, and the latch clears one edge after a completed turn-off. Inputs change on falling edges and outputs are read on falling edges. Each check is taken a couple of edges before its due edge (expecting the old value) and a couple of edges after it (expecting the new value). This brackets the edge without depending on the order of processes at it.

// File: rtl/psu_guard_pkg.sv
// Package for the power-supply guard.
// Holds the rail count and a helper that sizes tick counters.
package psu_guard_pkg;
    localparam int RAILS = 3;

    // Bits needed to hold a count from 0 up to and including n.
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/psu_persist.sv
// Persistence timer. The output is high while the input is high and the
// input has been sampled high on at least LEN ticks without a break.
// A low input zeroes the count. START_FULL sets the count to its limit
// at reset, so a timer whose input starts high also reads high at once.
// Assumes LEN >= 1 and a tick strobe at most one cycle wide.
module psu_persist
    import psu_guard_pkg::*;
#(
    parameter int LEN        = 73,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic level,
    output logic hit
);
    localparam int CW = cnt_bits(LEN);
    localparam logic [CW-1:0] LIMIT = CW'(LEN);

    logic [CW-1:0] cnt;

    // Count ticks of uninterrupted high input, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= START_FULL ? LIMIT : '0;
        else if (!level)
            cnt <= '0;
        else if (tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    // Report expiry only while the input is still present.
    always_comb hit = level && (cnt == LIMIT);
endmodule

// File: rtl/psu_debounce.sv
// Two-way debouncer for the on/off request. The filtered state takes
// the raw level only after LEN consecutive ticks on which the two differ.
// Resets to the off state (1). Assumes LEN >= 1.
module psu_debounce
    import psu_guard_pkg::*;
#(
    parameter int LEN = 38000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic state
);
    localparam int CW = cnt_bits(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Count ticks of disagreement and adopt the raw level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= 1'b1;
            cnt   <= '0;
        end else if (raw == state) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                state <= raw;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/psu_guard.sv
// Top of the power-supply guard. Debounces the on/off request, times the
// turn-off delay and the protection arming window, deglitches each fault
// flag and keeps the fault latch. The lockout input acts as a synchronous
// clear of everything. Assumes the tick strobe is at most one cycle wide.
module psu_guard
    import psu_guard_pkg::*;
#(
    parameter int DEB_TICKS = 38000,
    parameter int OFF_TICKS = 2300,
    parameter int OV_TICKS  = 73,
    parameter int OC_TICKS  = 73,
    parameter int UV_TICKS  = 150,
    parameter int ARM_TICKS = 75000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lockout,
    input  logic             on_req_n,
    input  logic             pg_in,
    input  logic [RAILS-1:0] ov_flag,
    input  logic [RAILS-1:0] oc_flag,
    input  logic             uv12_flag,
    output logic             rails_off,
    output logic             fault_held
);
    logic             clr_n;
    logic             req_off_q;
    logic             off_done;
    logic             off_done_q;
    logic             armed;
    logic             uv_hit;
    logic             turnoff_edge;
    logic             trip;
    logic [RAILS-1:0] ov_hit;
    logic [RAILS-1:0] oc_hit;

    // Reset and lockout both clear the block.
    always_comb clr_n = rst_n && !lockout;

    psu_debounce #(.LEN(DEB_TICKS)) u_req (
        .clk(clk), .rst_n(clr_n), .tick(tick),
        .raw(on_req_n), .state(req_off_q)
    );

    // Turn-off delay; starts full so the rails stay off out of reset.
    psu_persist #(.LEN(OFF_TICKS), .START_FULL(1'b1)) u_offdly (
        .clk(clk), .rst_n(clr_n), .tick(tick),
        .level(req_off_q), .hit(off_done)
    );

    // Arming window: request on and power-good high without a break.
    psu_persist #(.LEN(ARM_TICKS), .START_FULL(1'b0)) u_arm (
        .clk(clk), .rst_n(clr_n), .tick(tick),
        .level(!req_off_q && pg_in), .hit(armed)
    );

    // One deglitch timer per rail for over-voltage and over-current.
    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        psu_persist #(.LEN(OV_TICKS), .START_FULL(1'b0)) u_ov (
            .clk(clk), .rst_n(clr_n), .tick(tick),
            .level(ov_flag[r]), .hit(ov_hit[r])
        );
        psu_persist #(.LEN(OC_TICKS), .START_FULL(1'b0)) u_oc (
            .clk(clk), .rst_n(clr_n), .tick(tick),
            .level(oc_flag[r] && armed && pg_in), .hit(oc_hit[r])
        );
    end

    psu_persist #(.LEN(UV_TICKS), .START_FULL(1'b0)) u_uv (
        .clk(clk), .rst_n(clr_n), .tick(tick),
        .level(uv12_flag && armed && pg_in), .hit(uv_hit)
    );

    // Remember the turn-off delay output to find its rising edge.
    always_ff @(posedge clk) begin
        if (!clr_n) off_done_q <= 1'b1;
        else        off_done_q <= off_done;
    end

    // Combine the expired fault timers and detect a completed turn-off.
    always_comb begin
        trip         = (|ov_hit) || (|oc_hit) || uv_hit;
        turnoff_edge = off_done && !off_done_q;
    end

    // Fault latch: a completed turn-off clears it and wins over a new trip.
    always_ff @(posedge clk) begin
        if (!clr_n)            fault_held <= 1'b0;
        else if (turnoff_edge) fault_held <= 1'b0;
        else if (trip)         fault_held <= 1'b1;
    end

    // Rails off on a held fault or once the turn-off delay has run.
    always_comb rails_off = fault_held || off_done;
endmodule

// File: rtl/psu_guard_chk.sv
// Checker for psu_guard, attached by bind. It relates the ports to one
// another and to the debounced request state over time.
module psu_guard_chk
    import psu_guard_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lockout,
    input logic             pg_in,
    input logic [RAILS-1:0] ov_flag,
    input logic [RAILS-1:0] oc_flag,
    input logic             uv12_flag,
    input logic             rails_off,
    input logic             fault_held,
    input logic             req_off_q
);
    AST_LOCKOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (rails_off && !fault_held)); // R1

    AST_OFF_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rails_off) |-> (fault_held || req_off_q || $past(lockout))); // R4

    AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_held) |-> $past((|ov_flag) || (|oc_flag) || uv12_flag)); // R5

    AST_PG_LOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_held) && !$past(pg_in)) |-> $past(|ov_flag)); // R8

    AST_CLEAR_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_held) |-> (rails_off || $past(lockout))); // R10

    AST_HELD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_held |-> rails_off); // R10
endmodule

bind psu_guard psu_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lockout(lockout), .pg_in(pg_in),
    .ov_flag(ov_flag), .oc_flag(oc_flag), .uv12_flag(uv12_flag),
    .rails_off(rails_off), .fault_held(fault_held), .req_off_q(req_off_q)
);

// File: tb/sim_psu_guard.sv
// Directed bench for psu_guard with shortened tick windows.
module sim_psu_guard;
    localparam int DEB = 20;
    localparam int OFF = 10;
    localparam int OVT = 5;
    localparam int OCT = 5;
    localparam int UVT = 8;
    localparam int ARM = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       lockout = 1'b0;
    logic       on_req_n = 1'b1;
    logic       pg_in = 1'b1;
    logic [2:0] ov_flag = '0;
    logic [2:0] oc_flag = '0;
    logic       uv12_flag = 1'b0;
    logic       rails_off;
    logic       fault_held;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psu_guard #(
        .DEB_TICKS(DEB), .OFF_TICKS(OFF), .OV_TICKS(OVT),
        .OC_TICKS(OCT), .UV_TICKS(UVT), .ARM_TICKS(ARM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lockout(lockout),
        .on_req_n(on_req_n), .pg_in(pg_in), .ov_flag(ov_flag),
        .oc_flag(oc_flag), .uv12_flag(uv12_flag),
        .rails_off(rails_off), .fault_held(fault_held)
    );

    // Advance n rising edges and settle on the following falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // Turn the supply on from the off state and confirm the debounce edge.
    task automatic turn_on();
        on_req_n = 1'b0;
        edges(DEB - 2);
        check(rails_off, 1'b1, "R2 still off during debounce");
        edges(3);
        check(rails_off, 1'b0, "R3 on after debounce");
    endtask

    // Complete a turn-off and verify the delay and the latch clear.
    task automatic turn_off();
        on_req_n = 1'b1;
        edges(DEB + OFF - 2);
        check(rails_off, fault_held, "R4 off delay not yet run");
        edges(4);
        check(rails_off, 1'b1, "R4 off after delay");
        check(fault_held, 1'b0, "R10 latch cleared by turn-off");
    endtask

    task automatic t_reset();
        edges(3);
        rst_n = 1'b1;
        edges(1);
        check(rails_off, 1'b1, "R1 reset rails_off");
        check(fault_held, 1'b0, "R1 reset fault_held");
    endtask

    task automatic t_request_glitch();
        on_req_n = 1'b0;
        edges(DEB - 3);
        on_req_n = 1'b1;
        edges(DEB + 5);
        check(rails_off, 1'b1, "R2 short on-request ignored");
        turn_on();
    endtask

    task automatic t_ov();
        ov_flag[2] = 1'b1;
        edges(OVT - 2);
        ov_flag[2] = 1'b0;
        edges(1);
        ov_flag[2] = 1'b1;
        edges(OVT - 2);
        ov_flag[2] = 1'b0;
        edges(2);
        check(fault_held, 1'b0, "R9 broken OV pulses restart");
        ov_flag[2] = 1'b1;
        edges(OVT - 1);
        check(fault_held, 1'b0, "R5 OV before window");
        edges(3);
        check(fault_held, 1'b1, "R5 OV latched");
        check(rails_off, 1'b1, "R10 held fault forces off");
        ov_flag[2] = 1'b0;
        edges(10);
        check(fault_held, 1'b1, "R10 latch holds after flag drops");
        turn_off();
        turn_on();
    endtask

    task automatic t_oc_arming();
        turn_off();
        on_req_n = 1'b0;
        edges(DEB + 1);
        oc_flag[1] = 1'b1;
        edges(ARM - 14);
        check(fault_held, 1'b0, "R6 OC ignored before arming");
        oc_flag[1] = 1'b0;
        edges(20);
        oc_flag[0] = 1'b1;
        edges(OCT + 2);
        check(fault_held, 1'b1, "R6 OC latched once armed");
        oc_flag[0] = 1'b0;
        turn_off();
        turn_on();
    endtask

    task automatic t_pg_mask();
        edges(ARM + 5);
        pg_in = 1'b0;
        uv12_flag = 1'b1;
        oc_flag = 3'b111;
        edges(40);
        check(fault_held, 1'b0, "R8 UV/OC masked by pg low");
        check(rails_off, 1'b0, "R8 rails stay on with pg low");
        uv12_flag = 1'b0;
        oc_flag = '0;
        ov_flag[0] = 1'b1;
        edges(OVT + 2);
        check(fault_held, 1'b1, "R5 OV latches with pg low");
        ov_flag[0] = 1'b0;
        pg_in = 1'b1;
        turn_off();
        turn_on();
    endtask

    task automatic t_uv();
        edges(ARM + 2);
        uv12_flag = 1'b1;
        edges(UVT - 2);
        check(fault_held, 1'b0, "R7 UV before window");
        edges(4);
        check(fault_held, 1'b1, "R7 UV latched");
        uv12_flag = 1'b0;
    endtask

    task automatic t_lockout();
        lockout = 1'b1;
        edges(2);
        check(fault_held, 1'b0, "R1 lockout clears latch");
        check(rails_off, 1'b1, "R1 lockout forces off");
        lockout = 1'b0;
        edges(DEB - 3);
        check(rails_off, 1'b1, "R1 request re-debounced after lockout");
        edges(5);
        check(rails_off, 1'b0, "R3 on again after lockout");
    endtask

    task automatic t_tick_gate();
        tick = 1'b0;
        ov_flag[1] = 1'b1;
        edges(40);
        check(fault_held, 1'b0, "R11 no count without tick");
        tick = 1'b1;
        edges(OVT + 2);
        check(fault_held, 1'b1, "R11 counts resume with tick");
        ov_flag[1] = 1'b0;
        turn_off();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_request_glitch();
        t_ov();
        t_oc_arming();
        t_pg_mask();
        t_uv();
        t_lockout();
        t_tick_gate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule